// File: doc/BRIEF.md
# Dual-clock FIFO with programmable flags

This block buffers 36-bit words between two free-running clocks that may be unrelated or the same. A producer pushes words on the write clock through a valid/ready handshake. A consumer pops them in arrival order on the read clock through a second valid/ready handshake. The buffer holds 64 words in an inferred two-port memory. Each side keeps a binary pointer and a Gray-coded copy of it. Only the Gray copy crosses to the other clock, through a two-stage synchronizer. Each side therefore sees the other side's pointer a few of its own cycles late, so its flags err on the safe side.

The write side drives a full flag and an almost-full flag, and the read side drives an empty flag and an almost-empty flag. Each pair is registered in the clock domain that uses it. Each almost-threshold is a gap that software programs on the side that owns that flag. A gap may be loaded only while that side sees the buffer empty.

Back-pressure rules:
- A word is accepted on the rising write-clock edge where `wr_valid` and `wr_ready` are both high.
- A word is removed on the rising read-clock edge where `rd_valid` and `rd_ready` are both high.
- `rd_data` shows the oldest stored word whenever `rd_valid` is high.
- The producer may hold `wr_valid` high while `wr_ready` is low, and the consumer may hold `rd_ready` high while `rd_valid` is low. Neither has any effect.

Top module: `xdom_fifo`

## Requirements
- R1: Words leave the read port in exactly the order they were accepted at the write port, with all 36 bits intact. Up to 64 words can be held at once.
- R2: `wr_ready` is the inverse of `wr_full`. A word is stored only on a rising `wr_clk` edge with `wr_valid` and `wr_ready` both high. `wr_valid` while full stores nothing, and the write pointer does not move.
- R3: `rd_valid` is the inverse of `rd_empty`. A word is removed only on a rising `rd_clk` edge with `rd_valid` and `rd_ready` both high. `rd_ready` while empty removes nothing, and the read pointer does not move.
- R4: Synchronous resets (`wr_rst` on `wr_clk`, `rd_rst` on `rd_clk`, asserted together) bring the block to this state:
  - pointers cleared;
  - `wr_full` = 0 and `wr_afull` = 0;
  - `rd_empty` = 1 and `rd_aempty` = 1;
  - both gaps set to 8.
- R5: Once both clocks have run three cycles with no traffic, the flags match the stored count N. `wr_full` = 1 exactly when N = 64, and `rd_empty` = 1 exactly when N = 0.
- R6: In the same settled state, `wr_afull` = 1 exactly when N >= 64 − (almost-full gap). `wr_full` implies `wr_afull`.
- R7: In the same settled state, `rd_aempty` = 1 exactly when N <= (almost-empty gap). `rd_empty` implies `rd_aempty`.
- R8: The almost-full gap is loaded from `wr_cfg_gap` on a `wr_clk` edge with `wr_cfg_load` high, but only if the write side sees the buffer empty. The almost-empty gap is loaded from `rd_cfg_gap` on a `rd_clk` edge with `rd_cfg_load` high, but only if `rd_empty` is high. A load attempted at any other time is ignored. Valid gaps are 1 to 63.
- R9: Each Gray pointer that crosses clock domains changes in at most one bit per edge of its own clock.
- R10: The pointer distance (write minus read, modulo 128) never exceeds 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous reset, write domain |
| wr_valid | input | 1 | Producer offers a word |
| wr_ready | output | 1 | Buffer can take a word |
| wr_data | input | 36 | Word offered by the producer |
| wr_full | output | 1 | 64 words stored (write-side view) |
| wr_afull | output | 1 | Count at or above 64 minus the almost-full gap |
| wr_cfg_load | input | 1 | Load almost-full gap |
| wr_cfg_gap | input | 7 | New almost-full gap |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous reset, read domain |
| rd_valid | output | 1 | Oldest word is on rd_data |
| rd_ready | input | 1 | Consumer takes the word |
| rd_data | output | 36 | Oldest stored word |
| rd_empty | output | 1 | No words stored (read-side view) |
| rd_aempty | output | 1 | Count at or below the almost-empty gap |
| rd_cfg_load | input | 1 | Load almost-empty gap |
| rd_cfg_gap | input | 7 | New almost-empty gap |

## Verification
A directed fill-to-capacity with the consumer stalled, followed by a full drain, walks the stored count through every value. At each step it compares full, almost-full, empty and almost-empty against the count, which separates off-by-one errors at 55/56 and 8/9 from a threshold computed against the wrong end.

Pushing while full and popping while empty separate a correct refusal from pointer creep, which shows up as a lost word or a duplicated word in the next read-back. Reprogramming the gaps once while empty and once while holding data separates a guarded load from an unguarded one.

A long random phase throttles both sides independently on clocks of unequal period. It repeatedly crosses empty and full boundaries and checks every word's order and value against a model queue.

// File: rtl/xdom_fifo_pkg.sv
package xdom_fifo_pkg;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction

endpackage

// File: rtl/xdom_sync.sv
module xdom_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= '0;
        else if (i == 0) stage_q[i] <= d;
        else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xdom_ram.sv
module xdom_ram #(
  parameter int DW    = 36,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/xdom_wr_side.sv
module xdom_wr_side
  import xdom_fifo_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int GAP_RESET = 8,
  localparam int PW       = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          cfg_load,
  input  logic [PW-1:0] cfg_gap,
  input  logic [PW-1:0] rgray_s,
  output logic          push,
  output logic          full,
  output logic          afull,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray
);
  logic [PW-1:0] wbin_q, wgray_q, wbin_nx, rbin_s, cnt_nx, gap_q;
  logic          full_q, afull_q;

  assign push    = push_req & ~full_q;
  assign wbin_nx = wbin_q + PW'(push);
  assign rbin_s  = PW'(from_gray(32'(rgray_s)));
  assign cnt_nx  = wbin_nx - rbin_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b0;
      gap_q   <= PW'(GAP_RESET);
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= PW'(to_gray(32'(wbin_nx)));
      full_q  <= (cnt_nx == PW'(DEPTH));
      afull_q <= (cnt_nx >= PW'(DEPTH) - gap_q);
      if (cfg_load && (wbin_q == rbin_s)) gap_q <= cfg_gap;
    end
  end

  assign full  = full_q;
  assign afull = afull_q;
  assign wbin  = wbin_q;
  assign wgray = wgray_q;
endmodule

// File: rtl/xdom_rd_side.sv
module xdom_rd_side
  import xdom_fifo_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int GAP_RESET = 8,
  localparam int PW       = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop_req,
  input  logic          cfg_load,
  input  logic [PW-1:0] cfg_gap,
  input  logic [PW-1:0] wgray_s,
  output logic          empty,
  output logic          aempty,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray
);
  logic [PW-1:0] rbin_q, rgray_q, rbin_nx, wbin_s, gap_q;
  logic          empty_q, aempty_q, pop;

  assign pop     = pop_req & ~empty_q;
  assign rbin_nx = rbin_q + PW'(pop);
  assign wbin_s  = PW'(from_gray(32'(wgray_s)));

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
      gap_q    <= PW'(GAP_RESET);
    end else begin
      rbin_q   <= rbin_nx;
      rgray_q  <= PW'(to_gray(32'(rbin_nx)));
      empty_q  <= (wbin_s == rbin_nx);
      aempty_q <= ((wbin_s - rbin_nx) <= gap_q);
      if (cfg_load && empty_q) gap_q <= cfg_gap;
    end
  end

  assign empty  = empty_q;
  assign aempty = aempty_q;
  assign rbin   = rbin_q;
  assign rgray  = rgray_q;
endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo #(
  parameter int DW          = 36,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2,
  parameter int GAP_RESET   = 8
) (
  input  logic                   wr_clk,
  input  logic                   wr_rst,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [DW-1:0]          wr_data,
  output logic                   wr_full,
  output logic                   wr_afull,
  input  logic                   wr_cfg_load,
  input  logic [$clog2(DEPTH):0] wr_cfg_gap,
  input  logic                   rd_clk,
  input  logic                   rd_rst,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [DW-1:0]          rd_data,
  output logic                   rd_empty,
  output logic                   rd_aempty,
  input  logic                   rd_cfg_load,
  input  logic [$clog2(DEPTH):0] rd_cfg_gap
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray, wgray_s, rgray_s;
  logic          push;

  xdom_wr_side #(.DEPTH(DEPTH), .GAP_RESET(GAP_RESET)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .push_req(wr_valid),
    .cfg_load(wr_cfg_load), .cfg_gap(wr_cfg_gap), .rgray_s(rgray_s),
    .push(push), .full(wr_full), .afull(wr_afull),
    .wbin(wptr_bin), .wgray(wptr_gray)
  );

  xdom_rd_side #(.DEPTH(DEPTH), .GAP_RESET(GAP_RESET)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .pop_req(rd_ready),
    .cfg_load(rd_cfg_load), .cfg_gap(rd_cfg_gap), .wgray_s(wgray_s),
    .empty(rd_empty), .aempty(rd_aempty),
    .rbin(rptr_bin), .rgray(rptr_gray)
  );

  xdom_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wptr_gray), .q(wgray_s)
  );

  xdom_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rptr_gray), .q(rgray_s)
  );

  xdom_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(wr_clk), .we(push), .waddr(wptr_bin[AW-1:0]), .wdata(wr_data),
    .raddr(rptr_bin[AW-1:0]), .rdata(rd_data)
  );

  assign wr_ready = ~wr_full;
  assign rd_valid = ~rd_empty;
endmodule

// File: rtl/xdom_fifo_chk.sv
module xdom_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          wr_clk,
  input logic          wr_rst,
  input logic          wr_valid,
  input logic          wr_full,
  input logic          wr_afull,
  input logic          rd_clk,
  input logic          rd_rst,
  input logic          rd_ready,
  input logic          rd_empty,
  input logic          rd_aempty,
  input logic [PW-1:0] wptr_bin,
  input logic [PW-1:0] wptr_gray,
  input logic [PW-1:0] rptr_bin,
  input logic [PW-1:0] rptr_gray
);
  a_r2_no_push_when_full: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_valid && wr_full) |=> $stable(wptr_bin));

  a_r3_no_pop_when_empty: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_ready && rd_empty) |=> $stable(rptr_bin));

  a_r4_wr_reset_flags: assert property (@(posedge wr_clk)
    wr_rst |=> (!wr_full && !wr_afull));

  a_r4_rd_reset_flags: assert property (@(posedge rd_clk)
    rd_rst |=> (rd_empty && rd_aempty));

  a_r6_full_in_afull: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_full |-> wr_afull);

  a_r7_empty_in_aempty: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_empty |-> rd_aempty);

  a_r9_wgray_one_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $onehot0(wptr_gray ^ $past(wptr_gray)));

  a_r9_rgray_one_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $onehot0(rptr_gray ^ $past(rptr_gray)));

  a_r10_no_overflow: assert property (@(posedge wr_clk) disable iff (wr_rst)
    PW'(wptr_bin - rptr_bin) <= PW'(DEPTH));
endmodule

bind xdom_fifo xdom_fifo_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_xdom_fifo.sv
module test_xdom_fifo;
  localparam int DW    = 36;
  localparam int DEPTH = 64;
  localparam int PW    = 7;

  logic          wr_clk = 0, rd_clk = 0;
  logic          wr_rst = 1, rd_rst = 1;
  logic          wr_valid = 0, rd_ready = 0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_cfg_load = 0, rd_cfg_load = 0;
  logic [PW-1:0] wr_cfg_gap = '0, rd_cfg_gap = '0;
  logic          wr_ready, wr_full, wr_afull, rd_valid, rd_empty, rd_aempty;
  logic [DW-1:0] rd_data;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] model_q [$];
  int af_gap = 8, ae_gap = 8;

  always #4 wr_clk = ~wr_clk;
  always #5.5 rd_clk = ~rd_clk;

  xdom_fifo i_xdom_fifo (.*);

  function automatic bit exp_afull(int n, int gap);
    return n >= DEPTH - gap;
  endfunction

  function automatic bit exp_aempty(int n, int gap);
    return n <= gap;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_one(input logic [DW-1:0] d);
    bit r;
    wr_valid = 1; wr_data = d;
    do begin
      r = wr_ready;
      @(negedge wr_clk);
    end while (!r);
    wr_valid = 0;
    model_q.push_back(d);
  endtask

  task automatic rd_one(output logic [DW-1:0] d);
    bit v;
    rd_ready = 1;
    do begin
      v = rd_valid; d = rd_data;
      @(negedge rd_clk);
    end while (!v);
    rd_ready = 0;
  endtask

  task automatic rd_check(input string req);
    logic [DW-1:0] got, exp;
    rd_one(got);
    exp = model_q.pop_front();
    chk(got == exp, req, got, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge wr_clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (5) @(negedge rd_clk);
    @(negedge wr_clk); wr_rst = 0;
    @(negedge rd_clk); rd_rst = 0;
    settle();

    // R4: reset state
    chk(!wr_full && !wr_afull && wr_ready, "R4 wr flags", {wr_full, wr_afull, wr_ready}, 3'b001);
    chk(rd_empty && rd_aempty && !rd_valid, "R4 rd flags", {rd_empty, rd_aempty, rd_valid}, 3'b110);

    // R1/R5/R6: fill with consumer stalled, default gap 8
    @(negedge wr_clk);
    for (int n = 1; n <= DEPTH; n++) begin
      wr_one({4'ha, 32'(n * 32'h0101_0101)});
      chk(wr_afull == exp_afull(n, af_gap), "R6 afull during fill", wr_afull, exp_afull(n, af_gap));
      chk(wr_full == (n == DEPTH), "R5 full during fill", wr_full, n == DEPTH);
    end

    // R2: push attempts while full are refused
    wr_valid = 1; wr_data = 36'hdead_beef_f;
    repeat (6) begin
      @(negedge wr_clk);
      chk(!wr_ready, "R2 ready low while full", wr_ready, 0);
    end
    wr_valid = 0;
    settle();
    chk(!rd_aempty && rd_valid, "R5 rd side sees data", {rd_aempty, rd_valid}, 2'b01);

    // R1/R5/R7: drain, checking order and flags
    @(negedge rd_clk);
    for (int n = DEPTH - 1; n >= 0; n--) begin
      rd_check("R1 order after fill");
      chk(rd_aempty == exp_aempty(n, ae_gap), "R7 aempty during drain", rd_aempty, exp_aempty(n, ae_gap));
      chk(rd_empty == (n == 0), "R5 empty during drain", rd_empty, n == 0);
    end

    // R3: pop attempts while empty are refused
    rd_ready = 1;
    repeat (6) begin
      @(negedge rd_clk);
      chk(!rd_valid, "R3 valid low while empty", rd_valid, 0);
    end
    rd_ready = 0;
    @(negedge wr_clk);
    wr_one(36'h5_a5a5_a5a5);
    settle();
    @(negedge rd_clk);
    rd_check("R3 no pointer creep");
    settle();

    // R8: load gaps while empty
    @(negedge wr_clk); wr_cfg_load = 1; wr_cfg_gap = 7'd20;
    @(negedge wr_clk); wr_cfg_load = 0;
    @(negedge rd_clk); rd_cfg_load = 1; rd_cfg_gap = 7'd5;
    @(negedge rd_clk); rd_cfg_load = 0;
    af_gap = 20; ae_gap = 5;
    @(negedge wr_clk);
    for (int n = 1; n <= 50; n++) begin
      wr_one(36'(n) ^ 36'h3_0000_0000);
      chk(wr_afull == exp_afull(n, af_gap), "R8 new afull gap", wr_afull, exp_afull(n, af_gap));
    end
    settle();

    // R8: loads while holding data are ignored
    @(negedge wr_clk); wr_cfg_load = 1; wr_cfg_gap = 7'd2;
    @(negedge wr_clk); wr_cfg_load = 0;
    @(negedge rd_clk); rd_cfg_load = 1; rd_cfg_gap = 7'd40;
    @(negedge rd_clk); rd_cfg_load = 0;
    settle();
    chk(wr_afull == 1, "R8 afull gap kept", wr_afull, 1);
    @(negedge rd_clk);
    for (int n = 49; n >= 0; n--) begin
      rd_check("R1 order after reload");
      chk(rd_aempty == exp_aempty(n, ae_gap), "R8 aempty gap kept", rd_aempty, exp_aempty(n, ae_gap));
    end

    // R1/R2/R3: random throttling on both sides
    fork
      begin
        @(negedge wr_clk);
        for (int i = 0; i < 2000; i++) begin
          repeat ($urandom % 3) @(negedge wr_clk);
          wr_one({$urandom, 4'($urandom)});
        end
      end
      begin
        @(negedge rd_clk);
        for (int i = 0; i < 2000; i++) begin
          repeat ($urandom % 4) @(negedge rd_clk);
          rd_check("R1 random order");
        end
      end
    join
    settle();
    chk(rd_empty && !wr_full && !wr_afull, "R5 final settle", {rd_empty, wr_full, wr_afull}, 3'b100);
    chk(model_q.size() == 0, "R1 nothing left", model_q.size(), 0);
    finish_run();
  end
endmodule